// File: doc/BRIEF.md
# Board Interrupt Aggregator Register Bank

This block collects sixteen board-level interrupt inputs into a single upstream interrupt line. It also holds a small set of general control words for board LEDs, switches, miscellaneous controls and two card slots. A processor reaches every word through a simple synchronous register bus. The bus carries an 8-bit offset, a write strobe, a read strobe, 32-bit write data and registered 32-bit read data.

Each cycle the block compares every input with the level it recorded on the previous clock. When an input changes and its enable bit is set, the status word is replaced with a one-hot code that names that input. The upstream line then takes that input's new level. A change on an input whose enable bit is clear only updates the recorded level. Writes to the enable word and the status word pass through a fixed pattern of legal bits. Every other mapped word is plain 32-bit storage.

Top module: `brdirq_bank`

## Requirements
- R1: A synchronous active-high reset clears every stored word, the per-input level record, the read data and the upstream line to zero.
- R2: The ten plain words store and return all 32 bits of the last value written. Their offsets are 0x10 and 0x14 (LED data), 0x40 (LED control), 0x60 (switches), 0x80, 0x84 and 0x88 (misc write), 0x90 (misc read), and 0xE0 and 0xE4 (card slots).
- R3: A write to the enable word at offset 0xC0 stores the written value ANDed with 0x000FEEFF. Bit k of this word enables input k.
- R4: A write to the status word at offset 0xD0 stores the written value ANDed with 0x000FEEFF.
- R5: When input k changes and enable bit k is 1, the status word becomes 1<<k and the upstream line takes input k's new level. Both are visible after the first clock edge following the change.
- R6: When an input changes while its enable bit is 0, the status word and the upstream line keep their values.
- R7: When several enabled inputs change in the same cycle, the lowest-numbered one sets the status word and the upstream level.
- R8: When an enabled input change and a status write happen in the same cycle, the status word takes the input-change code.
- R9: A read from an offset outside the map returns zero, and a write to such an offset changes no mapped word.
- R10: Read data appears on the clock edge after the read strobe and holds its value while no read is requested.
- R11: The level record follows every input on each clock, including inputs that are not enabled. Enabling an input whose level changed earlier raises no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busAddr | input | 8 | Register offset |
| busWe | input | 1 | Write strobe |
| busRe | input | 1 | Read strobe |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |
| irqIn | input | 16 | Raw interrupt inputs, synchronous to clk |
| irqUp | output | 1 | Upstream interrupt line |

## Verification
The interrupt path is driven in several patterns, and each one separates a different behaviour. Single rising and falling edges on enabled inputs show that the upstream line follows the level rather than latching high. Edges on inputs blocked by the legal-bit pattern or by the enable word show that masking holds the status and the line still. Two simultaneous changes in opposite directions show that the lowest index wins, because the line ends at that input's level. An edge that coincides with a status write shows that the event overrides the bus, and enabling an input whose level moved earlier shows that the level record tracked it while it was masked.

// File: rtl/brdirq_pkg.sv
package brdirq_pkg;

  localparam int NUM_IRQ   = 16;
  localparam int IRQ_IDX_W = $clog2(NUM_IRQ);
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 8;
  localparam int NUM_PLAIN = 10;
  localparam int SEL_W     = $clog2(NUM_PLAIN + 2);

  // Bits that survive a write to the enable or status word
  localparam logic [DATA_W-1:0] VALID_BITS = 32'h000F_EEFF;

  localparam logic [ADDR_W-1:0] OFF_MASK   = 8'hC0;
  localparam logic [ADDR_W-1:0] OFF_STATUS = 8'hD0;

  localparam logic [SEL_W-1:0] SEL_MASK   = SEL_W'(NUM_PLAIN);
  localparam logic [SEL_W-1:0] SEL_STATUS = SEL_W'(NUM_PLAIN + 1);

  // Offset of plain storage word idx
  function automatic logic [ADDR_W-1:0] plainOffset(input int idx);
    case (idx)
      0:       return 8'h10;  // LED data A
      1:       return 8'h14;  // LED data B
      2:       return 8'h40;  // LED control
      3:       return 8'h60;  // switch state
      4:       return 8'h80;  // misc write 0
      5:       return 8'h84;  // misc write 1
      6:       return 8'h88;  // misc write 2
      7:       return 8'h90;  // misc read
      8:       return 8'hE0;  // card slot A
      9:       return 8'hE4;  // card slot B
      default: return 8'hFF;
    endcase
  endfunction

  typedef struct packed {
    logic [NUM_PLAIN-1:0] plainWe;
    logic                 maskWe;
    logic                 statusWe;
    logic                 rdEn;
    logic                 rdHit;
    logic [SEL_W-1:0]     rdSel;
    logic                 evtValid;
    logic [IRQ_IDX_W-1:0] evtIdx;
    logic                 evtLevel;
  } strobe_t;

endpackage

// File: rtl/brdirq_ctrl.sv
module brdirq_ctrl
  import brdirq_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWe,
  input  logic               busRe,
  input  logic [NUM_IRQ-1:0] irqIn,
  input  logic [NUM_IRQ-1:0] maskEn,
  output strobe_t            str
);

  logic [NUM_PLAIN-1:0] hitPlain;
  logic                 hitMask;
  logic                 hitStatus;
  logic [SEL_W-1:0]     rdSelC;
  logic [NUM_IRQ-1:0]   levelQ;
  logic [NUM_IRQ-1:0]   enChg;
  logic [IRQ_IDX_W-1:0] evtIdxC;

  genvar g;
  generate
    for (g = 0; g < NUM_PLAIN; g++) begin : g_hit
      assign hitPlain[g] = (busAddr == plainOffset(g));
    end
  endgenerate

  assign hitMask   = (busAddr == OFF_MASK);
  assign hitStatus = (busAddr == OFF_STATUS);

  always_comb begin
    rdSelC = '0;
    for (int i = 0; i < NUM_PLAIN; i++) begin
      if (hitPlain[i]) rdSelC = SEL_W'(i);
    end
    if (hitMask)   rdSelC = SEL_MASK;
    if (hitStatus) rdSelC = SEL_STATUS;
  end

  // Level record: tracks every input, enabled or not
  always_ff @(posedge clk) begin
    if (rst) levelQ <= '0;
    else     levelQ <= irqIn;
  end

  assign enChg = (irqIn ^ levelQ) & maskEn;

  // Lowest-numbered enabled change wins
  always_comb begin
    evtIdxC = '0;
    for (int i = NUM_IRQ - 1; i >= 0; i--) begin
      if (enChg[i]) evtIdxC = IRQ_IDX_W'(i);
    end
  end

  always_comb begin
    str.plainWe  = hitPlain & {NUM_PLAIN{busWe}};
    str.maskWe   = hitMask & busWe;
    str.statusWe = hitStatus & busWe;
    str.rdEn     = busRe;
    str.rdHit    = (|hitPlain) | hitMask | hitStatus;
    str.rdSel    = rdSelC;
    str.evtValid = |enChg;
    str.evtIdx   = evtIdxC;
    str.evtLevel = irqIn[evtIdxC];
  end

  // R7: chosen event is a real enabled change with none below it
  p_lowest_wins_r7: assert property (@(posedge clk) disable iff (rst)
    str.evtValid |-> (enChg[str.evtIdx] &&
      ((enChg & ((NUM_IRQ'(1) << str.evtIdx) - NUM_IRQ'(1))) == '0)));

  // R11: record holds the previous cycle's inputs
  p_level_track_r11: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (levelQ == $past(irqIn)));

endmodule

// File: rtl/brdirq_dp.sv
module brdirq_dp
  import brdirq_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [DATA_W-1:0]  busWdata,
  input  strobe_t            str,
  output logic [DATA_W-1:0]  busRdata,
  output logic [NUM_IRQ-1:0] maskEn,
  output logic               irqUp
);

  logic [DATA_W-1:0] plainQ [NUM_PLAIN];
  logic [DATA_W-1:0] maskQ;
  logic [DATA_W-1:0] statusQ;
  logic [DATA_W-1:0] rdVal;
  logic [DATA_W-1:0] rdataQ;
  logic              upQ;

  genvar g;
  generate
    for (g = 0; g < NUM_PLAIN; g++) begin : g_plain
      always_ff @(posedge clk) begin
        if (rst)                 plainQ[g] <= '0;
        else if (str.plainWe[g]) plainQ[g] <= busWdata;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)             maskQ <= '0;
    else if (str.maskWe) maskQ <= busWdata & VALID_BITS;
  end

  // Input event overrides a same-cycle bus write
  always_ff @(posedge clk) begin
    if (rst)                statusQ <= '0;
    else if (str.evtValid)  statusQ <= DATA_W'(1) << str.evtIdx;
    else if (str.statusWe)  statusQ <= busWdata & VALID_BITS;
  end

  always_ff @(posedge clk) begin
    if (rst)               upQ <= 1'b0;
    else if (str.evtValid) upQ <= str.evtLevel;
  end

  always_comb begin
    rdVal = '0;
    if (str.rdHit) begin
      if (str.rdSel == SEL_MASK)        rdVal = maskQ;
      else if (str.rdSel == SEL_STATUS) rdVal = statusQ;
      else begin
        for (int i = 0; i < NUM_PLAIN; i++) begin
          if (str.rdSel == SEL_W'(i)) rdVal = plainQ[i];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           rdataQ <= '0;
    else if (str.rdEn) rdataQ <= rdVal;
  end

  assign busRdata = rdataQ;
  assign maskEn   = maskQ[NUM_IRQ-1:0];
  assign irqUp    = upQ;

  // R5: an event leaves a one-hot status naming it and the line at its level
  p_event_code_r5: assert property (@(posedge clk) disable iff (rst)
    str.evtValid |=> ($onehot(statusQ) && statusQ[$past(str.evtIdx)] &&
                      (irqUp == $past(str.evtLevel))));

  // R6: without an event or a status write both stay put
  p_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (!str.evtValid && !str.statusWe) |=> ($stable(statusQ) && $stable(irqUp)));

  // R3: enable word only keeps legal bits
  p_mask_filter_r3: assert property (@(posedge clk) disable iff (rst)
    str.maskWe |=> (maskQ == ($past(busWdata) & VALID_BITS)));

  // R4: status write without event only keeps legal bits
  p_status_filter_r4: assert property (@(posedge clk) disable iff (rst)
    (str.statusWe && !str.evtValid) |=> (statusQ == ($past(busWdata) & VALID_BITS)));

  // R9: unmapped read returns zero
  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (str.rdEn && !str.rdHit) |=> (busRdata == '0));

  // R10: read data holds without a read
  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !str.rdEn |=> $stable(busRdata));

endmodule

// File: rtl/brdirq_bank.sv
module brdirq_bank
  import brdirq_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWe,
  input  logic               busRe,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  input  logic [NUM_IRQ-1:0] irqIn,
  output logic               irqUp
);

  strobe_t            str;
  logic [NUM_IRQ-1:0] maskEn;

  brdirq_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .busAddr (busAddr),
    .busWe   (busWe),
    .busRe   (busRe),
    .irqIn   (irqIn),
    .maskEn  (maskEn),
    .str     (str)
  );

  brdirq_dp u_dp (
    .clk      (clk),
    .rst      (rst),
    .busWdata (busWdata),
    .str      (str),
    .busRdata (busRdata),
    .maskEn   (maskEn),
    .irqUp    (irqUp)
  );

endmodule

// File: tb/brdirq_bank_test.sv
`timescale 1ns/1ps
module brdirq_bank_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic        busRe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [15:0] irqIn = '0;
  logic        irqUp;

  int cmpCount = 0;
  int errCount = 0;
  bit done = 0;

  logic [31:0] expQ[$];
  string       tagQ[$];
  logic        pending = 1'b0;

  logic [7:0] offs [10] = '{8'h10, 8'h14, 8'h40, 8'h60, 8'h80,
                            8'h84, 8'h88, 8'h90, 8'hE0, 8'hE4};

  always #4 clk = ~clk;

  brdirq_bank uut (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busWe(busWe), .busRe(busRe),
    .busWdata(busWdata), .busRdata(busRdata), .irqIn(irqIn), .irqUp(irqUp)
  );

  // Monitor: a read issued before an edge is compared at the following negedge
  always @(posedge clk) pending <= busRe;

  always @(negedge clk) begin
    if (pending) begin
      cmpCount++;
      if (expQ.size() == 0) begin
        errCount++;
        $display("FAIL scoreboard empty: actual %h expected none", busRdata);
      end else begin
        logic [31:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        if (busRdata !== e) begin
          errCount++;
          $display("FAIL %s: actual %h expected %h", t, busRdata, e);
        end
      end
    end
  end

  task automatic doWrite(input logic [7:0] a, input logic [31:0] d);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(posedge clk); @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic doRead(input logic [7:0] a, input logic [31:0] e, input string t);
    busAddr = a; busRe = 1'b1;
    expQ.push_back(e); tagQ.push_back(t);
    @(posedge clk); @(negedge clk);
    busRe = 1'b0;
  endtask

  task automatic setIrq(input logic [15:0] v);
    irqIn = v;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic checkVal(input logic [31:0] act, input logic [31:0] e, input string t);
    cmpCount++;
    if (act !== e) begin
      errCount++;
      $display("FAIL %s: actual %h expected %h", t, act, e);
    end
  endtask

  task automatic doReset();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", cmpCount, errCount);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    cmpCount++; errCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [31:0] lastRd;
    doReset();
    // R1 reset state
    checkVal({31'b0, irqUp}, 32'h0, "R1 upstream after reset");
    checkVal(busRdata, 32'h0, "R1 read data after reset");
    doRead(8'hC0, 32'h0, "R1 enable word after reset");
    doRead(8'hD0, 32'h0, "R1 status after reset");
    doRead(8'h90, 32'h0, "R1 plain word after reset");

    // R2 plain storage
    for (int i = 0; i < 10; i++) doWrite(offs[i], {8'hA5, 8'(i), 8'h5A, offs[i]});
    for (int i = 0; i < 10; i++) doRead(offs[i], {8'hA5, 8'(i), 8'h5A, offs[i]}, "R2 plain readback");

    // R3 / R4 legal-bit filtering
    doWrite(8'hC0, 32'h0000_0100);
    doRead(8'hC0, 32'h0, "R3 enable bit 8 filtered");
    doWrite(8'hD0, 32'h1234_5678);
    doRead(8'hD0, 32'h0004_4678, "R4 status filtered");
    doWrite(8'hD0, 32'hFFFF_FFFF);
    doRead(8'hD0, 32'h000F_EEFF, "R4 status all ones");
    doWrite(8'hC0, 32'hFFFF_FFFF);
    doRead(8'hC0, 32'h000F_EEFF, "R3 enable all ones");

    // R9 unmapped offsets
    doWrite(8'h20, 32'hFFFF_FFFF);
    doWrite(8'hC4, 32'h0);
    doRead(8'h20, 32'h0, "R9 unmapped read zero");
    doRead(8'hC4, 32'h0, "R9 unmapped near enable");
    doRead(8'hC0, 32'h000F_EEFF, "R9 enable unchanged by unmapped write");
    doRead(8'h10, {8'hA5, 8'd0, 8'h5A, 8'h10}, "R9 plain unchanged");

    // R5 enabled edges both ways
    setIrq(16'h0008);
    checkVal({31'b0, irqUp}, 32'h1, "R5 line high on rise");
    doRead(8'hD0, 32'h0000_0008, "R5 status bit 3");
    setIrq(16'h0000);
    checkVal({31'b0, irqUp}, 32'h0, "R5 line low on fall");
    doRead(8'hD0, 32'h0000_0008, "R5 status after fall");
    setIrq(16'h0020);
    doRead(8'hD0, 32'h0000_0020, "R5 status bit 5");

    // R6 masked changes
    setIrq(16'h0120);
    checkVal({31'b0, irqUp}, 32'h1, "R6 line held on bit 8");
    doRead(8'hD0, 32'h0000_0020, "R6 status held on bit 8");
    doWrite(8'hC0, 32'h0000_0001);
    setIrq(16'h0160);
    checkVal({31'b0, irqUp}, 32'h1, "R6 line held on bit 6");
    doRead(8'hD0, 32'h0000_0020, "R6 status held on bit 6");

    // R11 level record kept while masked
    doWrite(8'hC0, 32'hFFFF_FFFF);
    @(posedge clk); @(negedge clk);
    doRead(8'hD0, 32'h0000_0020, "R11 no event on enable");
    checkVal({31'b0, irqUp}, 32'h1, "R11 line unchanged on enable");
    setIrq(16'h0120);
    doRead(8'hD0, 32'h0000_0040, "R11 later fall seen");
    checkVal({31'b0, irqUp}, 32'h0, "R11 line follows fall");

    // R7 priority
    setIrq(16'h0324);
    doRead(8'hD0, 32'h0000_0004, "R7 bit 2 beats bit 9");
    checkVal({31'b0, irqUp}, 32'h1, "R7 line rise");
    setIrq(16'h0720);
    doRead(8'hD0, 32'h0000_0004, "R7 bit 2 fall beats bit 10 rise");
    checkVal({31'b0, irqUp}, 32'h0, "R7 line follows lowest");

    // R8 event beats status write
    irqIn = 16'h0730; busAddr = 8'hD0; busWdata = 32'h0; busWe = 1'b1;
    @(posedge clk); @(negedge clk);
    busWe = 1'b0;
    doRead(8'hD0, 32'h0000_0010, "R8 event wins");
    checkVal({31'b0, irqUp}, 32'h1, "R8 line high");

    // R10 timing and hold
    doWrite(8'h14, 32'hCAFE_F00D);
    doRead(8'h14, 32'hCAFE_F00D, "R10 read after write");
    lastRd = 32'hCAFE_F00D;
    busAddr = 8'h10;
    doWrite(8'h14, 32'h0BAD_BEEF);
    repeat (2) @(negedge clk);
    checkVal(busRdata, lastRd, "R10 read data held");

    // R1 reset mid-run
    doReset();
    checkVal({31'b0, irqUp}, 32'h0, "R1 line cleared");
    doRead(8'h14, 32'h0, "R1 plain cleared");
    doRead(8'hC0, 32'h0, "R1 enable cleared");
    doRead(8'hD0, 32'h0, "R1 status cleared");
    irqIn = 16'h0;
    @(negedge clk);
    finishRun();
  end

endmodule